// File: doc/BRIEF.md
# Six-Button Gamepad Port Multiplexer

This block models the data byte of a game controller port that presents different groups of buttons depending on a select bit written by the host. The host writes the port's data byte. Bit 6 of each write becomes the select level. Every falling step of the select, from high to low, advances a pulse counter. On particular counter values, the byte the host reads back shows a nibble of four extended buttons, or an all-ones identification nibble, in place of the normal direction bits.

An idle timer counts timeout ticks. If enough ticks arrive with no port write in between, the pulse counter falls back to zero, so the next burst of select pulses starts a fresh sequence. The counter never grows without bound. When an increment would take it past a high limit, a fixed amount is taken off. The counter then circulates among high values and never returns to the special low values.

Button inputs are active-low. The host reads either byte lane of the port. The even lane always reads zero.

Top module: `sixbtn_pad_port`

## Requirements
- R1: After reset the select level is 1, the pulse counter is 0 and the idle timer is 0. An odd-lane read with all buttons released (btn_n all ones) then returns 8'h7F.
- R2: A write (wr_en=1) sets the select level to wr_data[6] at the next clock edge.
- R3: The pulse counter advances by one only on a write with wr_data[6]=0 while the select level before that write was 1. Every other cycle leaves it unchanged, except for the timeout in R9.
- R4: With select=1 and counter not 3, an odd read returns {1'b0, 1'b1, btn_n[5:4], btn_n[3:0]}. In btn_n, bits 3:0 are the four directions (bit 0 up, bit 1 down), bits 5:4 are the first action pair, bits 7:6 are the second action pair, and bits 11:8 are the extended buttons.
- R5: With select=0 and counter neither 3 nor 4, an odd read returns {2'b00, btn_n[7:6], 2'b00, btn_n[1:0]}.
- R6: With select=0 and counter 4, an odd read returns {2'b00, btn_n[7:6], 4'b1111}.
- R7: With counter 3, an odd read returns {2'b01, btn_n[5:4], btn_n[11:8]} when select=1 and {2'b00, btn_n[7:6], 4'b0000} when select=0.
- R8: When an increment would give a value above CNT_HI, the counter takes that value minus CNT_FOLD instead. With the defaults 12 and 4, the 13th pulse gives 9, and the counter never exceeds CNT_HI.
- R9: Each tmo_tick without a write advances the idle timer. The tick that brings it to TMO_LIMIT clears both the timer and the pulse counter. Any write clears the timer, and a write in the same cycle as that final tick takes precedence, so the counter is not cleared.
- R10: A read of the even lane (rd_odd=0) returns 8'h00, and bit 7 of every read is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| btn_n | input | 12 | Button levels, active-low, layout as in R4 |
| wr_en | input | 1 | Host write strobe for the port data byte |
| wr_data | input | 8 | Written byte; bit 6 is the select level |
| rd_odd | input | 1 | 1 selects the odd byte lane, 0 the even lane |
| tmo_tick | input | 1 | Timeout tick for the idle timer |
| rd_data | output | 8 | Byte returned to the host |

## Verification
On every cycle, assertions check these behaviours:
- the select level follows written bit 6;
- the counter holds when it should and steps by one on a qualifying pulse;
- the counter stays within its upper bound;
- writes clear the idle timer, and an expiry clears the counter;
- the extended nibble appears on the lane at count 3;
- the even lane and bit 7 read zero.

Only the bench's scenarios can show the rest:
- the long pulse bursts that reach the fold point and must never revisit counts 3 or 4;
- a full idle timeout followed by a fresh sequence;
- the race between a write and the final tick.

// File: rtl/pad_port_pkg.sv
package pad_port_pkg;
  localparam int BTN_W  = 12;
  localparam int BYTE_W = 8;
  localparam int SEL_BIT = 6;

  // button positions inside btn_n
  localparam int B_UP    = 0;
  localparam int B_DOWN  = 1;
  localparam int B_ACT0  = 4;
  localparam int B_ACT1  = 6;
  localparam int B_EXT   = 8;

  typedef struct packed {
    logic       zero7;
    logic       sel;
    logic [1:0] act;
    logic [3:0] low;
  } pad_byte_t;
endpackage

// File: rtl/pad_th_tracker.sv
module pad_th_tracker #(
  parameter int CNT_W    = 4,
  parameter int CNT_HI   = 12,
  parameter int CNT_FOLD = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             th_bit,
  input  logic             expire,
  output logic             toggle,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W:0] HI_V   = (CNT_W+1)'(CNT_HI);
  localparam logic [CNT_W:0] FOLD_V = (CNT_W+1)'(CNT_FOLD);

  // advance the pulse count, folding back once it passes the high limit
  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c);
    logic [CNT_W:0] s;
    s = {1'b0, c} + 1'b1;
    if (s > HI_V) s = s - FOLD_V;
    return s[CNT_W-1:0];
  endfunction

  logic pulse;  // qualifying high-to-low select step
  assign pulse = wr_en & ~th_bit & toggle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      toggle <= 1'b1;
      cnt    <= '0;
    end else begin
      if (wr_en) toggle <= th_bit;
      if (pulse)       cnt <= step_count(cnt);
      else if (expire) cnt <= '0;
    end
  end

  p_toggle_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (toggle == $past(th_bit)));

  p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse && !expire) |=> $stable(cnt));

  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && ({1'b0, cnt} < HI_V)) |=> (cnt == $past(cnt) + 1'b1));

  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt} <= HI_V));
endmodule

// File: rtl/pad_idle_timer.sv
module pad_idle_timer #(
  parameter int TMO_LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic tick,
  output logic expire
);
  localparam int TMO_W = $clog2(TMO_LIMIT + 1);
  localparam logic [TMO_W-1:0] LAST_V = TMO_W'(TMO_LIMIT - 1);

  logic [TMO_W-1:0] tmo;

  assign expire = tick & ~wr_en & (tmo == LAST_V);

  always_ff @(posedge clk) begin
    if (!rst_n)                 tmo <= '0;
    else if (wr_en || expire)   tmo <= '0;
    else if (tick)              tmo <= tmo + 1'b1;
  end

  p_write_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (tmo == '0));

  p_timer_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo <= LAST_V));
endmodule

// File: rtl/pad_read_mux.sv
module pad_read_mux
  import pad_port_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic               toggle,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [BTN_W-1:0]   btn_n,
  input  logic               rd_odd,
  output logic [BYTE_W-1:0]  rd_data
);
  localparam logic [CNT_W-1:0] CNT_EXT = CNT_W'(3);
  localparam logic [CNT_W-1:0] CNT_ID  = CNT_W'(4);

  pad_byte_t v;

  always_comb begin
    v       = '0;
    v.sel   = toggle;
    if (toggle) begin
      v.act = btn_n[B_ACT0 +: 2];
      v.low = (cnt == CNT_EXT) ? btn_n[B_EXT +: 4] : btn_n[3:0];
    end else begin
      v.act = btn_n[B_ACT1 +: 2];
      if (cnt == CNT_EXT)     v.low = 4'b0000;
      else if (cnt == CNT_ID) v.low = 4'b1111;
      else                    v.low = {2'b00, btn_n[B_DOWN], btn_n[B_UP]};
    end
    rd_data = rd_odd ? v : '0;
  end
endmodule

// File: rtl/sixbtn_pad_port.sv
module sixbtn_pad_port
  import pad_port_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int CNT_HI    = 12,
  parameter int CNT_FOLD  = 4,
  parameter int TMO_LIMIT = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [11:0] btn_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_data,
  input  logic        rd_odd,
  input  logic        tmo_tick,
  output logic [7:0]  rd_data
);
  logic             expire;
  logic             toggle;
  logic [CNT_W-1:0] cnt;

  pad_idle_timer #(.TMO_LIMIT(TMO_LIMIT)) timer_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tick(tmo_tick), .expire(expire)
  );

  pad_th_tracker #(.CNT_W(CNT_W), .CNT_HI(CNT_HI), .CNT_FOLD(CNT_FOLD)) track_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .th_bit(wr_data[SEL_BIT]),
    .expire(expire), .toggle(toggle), .cnt(cnt)
  );

  pad_read_mux #(.CNT_W(CNT_W)) mux_i (
    .toggle(toggle), .cnt(cnt), .btn_n(btn_n), .rd_odd(rd_odd), .rd_data(rd_data)
  );

  p_expire_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt == '0));

  p_ext_nibble_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_odd && toggle && cnt == CNT_W'(3)) |-> (rd_data[3:0] == btn_n[11:8]));

  p_even_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_odd |-> (rd_data == 8'h00));

  p_bit7_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7] == 1'b0));
endmodule

// File: tb/sixbtn_pad_port_tb.sv
module sixbtn_pad_port_tb_top;
  localparam int HI   = 12;
  localparam int FOLD = 4;
  localparam int LIM  = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] btn_n = 12'hFFF;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        rd_odd = 1'b1;
  logic        tmo_tick = 1'b0;
  logic [7:0]  rd_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // model state
  bit m_tog;
  int m_cnt;
  int m_tmo;

  always #2 clk = ~clk;

  sixbtn_pad_port #(.CNT_W(4), .CNT_HI(HI), .CNT_FOLD(FOLD), .TMO_LIMIT(LIM)) dut_i (
    .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_odd(rd_odd), .tmo_tick(tmo_tick), .rd_data(rd_data)
  );

  function automatic logic [7:0] exp_read(bit tog, int c, logic [11:0] b, bit odd);
    logic [3:0] lo;
    if (!odd) return 8'h00;
    if (tog) begin
      lo = (c == 3) ? b[11:8] : b[3:0];
      return {2'b01, b[5:4], lo};
    end
    case (c)
      3:       lo = 4'h0;
      4:       lo = 4'hF;
      default: lo = {2'b00, b[1:0]};
    endcase
    return {2'b00, b[7:6], lo};
  endfunction

  function automatic int bumped(int c);
    int n = c + 1;
    if (n > HI) n = n - FOLD;
    return n;
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // one cycle: drive, clock, update model, compare
  task automatic step(string tag, bit w, logic [7:0] d, bit t, logic [11:0] b, bit odd);
    bit n_tog;
    int n_cnt, n_tmo;
    @(negedge clk);
    wr_en = w; wr_data = d; tmo_tick = t; btn_n = b; rd_odd = odd;
    n_tog = m_tog; n_cnt = m_cnt; n_tmo = m_tmo;
    if (w) begin
      n_tog = d[6];
      if (!d[6] && m_tog) n_cnt = bumped(m_cnt);
      n_tmo = 0;
    end else if (t) begin
      if (m_tmo == LIM - 1) begin n_cnt = 0; n_tmo = 0; end
      else n_tmo = m_tmo + 1;
    end
    @(posedge clk);
    #1;
    m_tog = n_tog; m_cnt = n_cnt; m_tmo = n_tmo;
    check(tag, rd_data, exp_read(m_tog, m_cnt, b, odd));
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] pat;
    void'($urandom(32'h5EED1234));
    m_tog = 1; m_cnt = 0; m_tmo = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #0;
    check("R1 reset read", rd_data, 8'h7F);
    pat = 12'b1010_01_10_0110;

    // R2/R5: first falling select
    step("R2 R5 write 00", 1, 8'h00, 0, pat, 1);
    step("R2 R4 write 40", 1, 8'h40, 0, pat, 1);
    step("R3 pulse to 2", 1, 8'h00, 0, pat, 1);
    step("R3 repeat low no pulse", 1, 8'h00, 0, pat, 1);
    step("R4 high", 1, 8'h40, 0, pat, 1);
    step("R7 count3 low", 1, 8'h00, 0, pat, 1);
    step("R7 count3 high ext", 1, 8'hFF, 0, pat, 1);
    step("R6 count4 id", 1, 8'h3F, 0, pat, 1);
    step("R4 count4 high", 1, 8'h40, 0, pat, 1);
    step("R10 even lane", 0, 8'h00, 0, pat, 0);

    // R8: long burst through the fold point
    for (int i = 0; i < 14; i++) begin
      step("R8 burst low", 1, 8'h00, 0, pat, 1);
      step("R8 burst high", 1, 8'h40, 0, pat, 1);
    end

    // R9: full timeout clears the counter
    for (int i = 0; i < LIM; i++) step("R9 idle ticks", 0, 8'h00, 1, pat, 1);
    for (int i = 0; i < 3; i++) begin
      step("R9 rebuild low", 1, 8'h00, 0, pat, 1);
      step("R9 rebuild high", 1, 8'h40, 0, pat, 1);
    end
    // now count 3, select high: write on the final tick must win
    for (int i = 0; i < LIM - 1; i++) step("R9 ticks", 0, 8'h00, 1, pat, 1);
    step("R9 write beats final tick", 1, 8'h40, 1, pat, 1);
    step("R9 timer restarted", 0, 8'h00, 1, pat, 1);
    step("R9 idle no tick", 0, 8'h00, 0, pat, 1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit w, t, o;
      logic [7:0] d;
      w = ($urandom % 4) == 0;
      t = ($urandom % 3) == 0;
      o = ($urandom % 5) != 0;
      d = 8'($urandom);
      step("R2 R3 R4 R5 R6 R7 R8 R9 R10 random", w, d, t, 12'($urandom), o);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule